// File: doc/BRIEF.md
# Shared Chained Minimum-SAD Comparator Element

This block is one link of a chain that searches for the smallest sum of absolute differences (SAD) and its motion vector for one partition size. A group of processing elements produces candidate SADs on consecutive clock cycles. This one element serves the whole group in turn. A free-running cycle count chooses which member of the group is examined on each cycle. On the first cycle of its window, the element compares against the minimum that the upstream element in the chain forwarded. On the later cycles of the window, it compares against its own stored minimum. A candidate that is strictly smaller is taken together with its motion vector. One cycle after the last slot of the window, the result is presented to the downstream element.

A chain of these elements covers a whole macroblock. Each element is built with its own window start and group size. This lets a small number of elements replace one comparator per partition. A macroblock-start pulse returns the stored minimum to its largest value before a new search.

Top module: `chain_min_cmp`

## Requirements
- R1: Out of reset, `fwd_sad` is all ones, `fwd_mv` is zero and `fwd_vld` is low.
- R2: A cycle with `mb_start` high loads all ones into the stored SAD and zero into the stored vector at the next edge. It takes priority over any comparison in that cycle and suppresses `fwd_vld` from that cycle.
- R3: Source `i` (SAD in bits `[i*SAD_W +: SAD_W]` of `pe_sad`, vector in bits `[i*MV_W +: MV_W]` of `pe_mv`) is examined only in the cycle where `cycle_cnt == START_CYC + i`. Sources are never examined outside the window `START_CYC .. START_CYC+NUM_SRC-1`.
- R4: In the first window cycle, the reference is `up_sad`/`up_mv`. The stored result becomes whichever of the reference and source 0 wins.
- R5: In the later window cycles, the reference is the stored minimum, so the final result is the minimum over the upstream value and all sources.
- R6: Only a strictly smaller SAD replaces the reference. On equal values, the earlier entry (upstream first, then lower source index) and its vector are kept.
- R7: `fwd_vld` is a one-cycle pulse, high in the cycle after the last window cycle. In that cycle, `fwd_sad`/`fwd_mv` hold the window's result.
- R8: Outside the window and without `mb_start`, the stored SAD and vector do not change, whatever `pe_sad` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_start | input | 1 | Macroblock start; clears the stored minimum to the maximum value |
| cycle_cnt | input | CNT_W | Global cycle count within the macroblock |
| pe_sad | input | NUM_SRC*SAD_W | Packed SADs of the shared processing elements |
| pe_mv | input | NUM_SRC*MV_W | Packed motion vectors paired with `pe_sad` |
| up_sad | input | SAD_W | Minimum SAD forwarded by the upstream element |
| up_mv | input | MV_W | Vector paired with `up_sad` |
| fwd_sad | output | SAD_W | Registered stored minimum SAD, sent downstream |
| fwd_mv | output | MV_W | Registered vector of `fwd_sad` |
| fwd_vld | output | 1 | Pulse marking `fwd_sad`/`fwd_mv` as the window result |

## Verification
The bench builds the element with its defaults: four shared sources, 16-bit SADs and vectors, a 9-bit count and a window that opens at cycle 51. With these values, each search spans only a few dozen cycles, and the counter can be driven past both ends of the window. This brings within reach the sources driven outside the window, ties between the upstream value and a source or between two sources, and saturated all-ones inputs. It also covers a macroblock-start pulse arriving inside the window, as well as the upstream value winning outright.

// File: rtl/cmp_pkg.sv
// Shared defaults for the chained minimum-SAD comparator element.
// Assumes: all sibling modules take their parameter defaults from here.
package cmp_pkg;
    localparam int DEF_NUM_SRC   = 4;
    localparam int DEF_SAD_W     = 16;
    localparam int DEF_MV_W      = 16;
    localparam int DEF_CNT_W     = 9;
    localparam int DEF_START_CYC = 51;
endpackage

// File: rtl/slot_decode.sv
// Turns the cycle count into a one-hot source select plus window flags.
// Assumes: START_CYC + NUM_SRC fits in CNT_W bits.
module slot_decode #(
    parameter int NUM_SRC   = cmp_pkg::DEF_NUM_SRC,
    parameter int CNT_W     = cmp_pkg::DEF_CNT_W,
    parameter int START_CYC = cmp_pkg::DEF_START_CYC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cycle_cnt,
    output logic [NUM_SRC-1:0] sel,
    output logic               in_win,
    output logic               first,
    output logic               last
);
    localparam logic [CNT_W-1:0] START_V = CNT_W'(START_CYC);
    localparam logic [CNT_W-1:0] LAST_O  = CNT_W'(NUM_SRC - 1);

    logic [CNT_W-1:0] off;

    // offset of the count from the window start
    always_comb begin
        off    = cycle_cnt - START_V;
        in_win = (cycle_cnt >= START_V) && (off <= LAST_O);
        first  = in_win && (off == '0);
        last   = in_win && (off == LAST_O);
    end

    // one select line per shared source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        assign sel[i] = in_win && (off == CNT_W'(i));
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && (in_win == (sel != '0)));
endmodule

// File: rtl/sad_pick.sv
// AND-OR selection of the examined source's SAD and motion vector.
// Assumes: sel is one-hot or zero; zero yields zero outputs.
module sad_pick #(
    parameter int NUM_SRC = cmp_pkg::DEF_NUM_SRC,
    parameter int SAD_W   = cmp_pkg::DEF_SAD_W,
    parameter int MV_W    = cmp_pkg::DEF_MV_W
) (
    input  logic [NUM_SRC-1:0]       sel,
    input  logic [NUM_SRC*SAD_W-1:0] pe_sad,
    input  logic [NUM_SRC*MV_W-1:0]  pe_mv,
    output logic [SAD_W-1:0]         cur_sad,
    output logic [MV_W-1:0]          cur_mv
);
    logic [NUM_SRC-1:0][SAD_W-1:0] sad_m;
    logic [NUM_SRC-1:0][MV_W-1:0]  mv_m;

    // mask each source by its select line
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        assign sad_m[i] = pe_sad[i*SAD_W +: SAD_W] & {SAD_W{sel[i]}};
        assign mv_m[i]  = pe_mv[i*MV_W +: MV_W]    & {MV_W{sel[i]}};
    end

    // merge the masked sources
    always_comb begin
        cur_sad = '0;
        cur_mv  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cur_sad = cur_sad | sad_m[i];
            cur_mv  = cur_mv  | mv_m[i];
        end
    end
endmodule

// File: rtl/ref_mux.sv
// 2:1 choice of comparison reference: upstream minimum or local store.
// Assumes: CHAINED=0 builds a chain head that always uses its own store.
module ref_mux #(
    parameter int SAD_W   = cmp_pkg::DEF_SAD_W,
    parameter int MV_W    = cmp_pkg::DEF_MV_W,
    parameter bit CHAINED = 1'b1
) (
    input  logic             first,
    input  logic [SAD_W-1:0] up_sad,
    input  logic [MV_W-1:0]  up_mv,
    input  logic [SAD_W-1:0] loc_sad,
    input  logic [MV_W-1:0]  loc_mv,
    output logic [SAD_W-1:0] ref_sad,
    output logic [MV_W-1:0]  ref_mv
);
    if (CHAINED) begin : g_chain
        // take the upstream minimum on the first window slot
        always_comb begin
            ref_sad = first ? up_sad : loc_sad;
            ref_mv  = first ? up_mv  : loc_mv;
        end
    end else begin : g_head
        // chain head: always compare with the local store
        always_comb begin
            ref_sad = loc_sad;
            ref_mv  = loc_mv;
        end
    end
endmodule

// File: rtl/min_store.sv
// Comparator plus stored SAD/MV registers and the forward-valid pulse.
// Assumes: in_win/last come from the slot decoder in the same cycle.
module min_store #(
    parameter int SAD_W = cmp_pkg::DEF_SAD_W,
    parameter int MV_W  = cmp_pkg::DEF_MV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mb_start,
    input  logic             in_win,
    input  logic             last,
    input  logic [SAD_W-1:0] cur_sad,
    input  logic [MV_W-1:0]  cur_mv,
    input  logic [SAD_W-1:0] ref_sad,
    input  logic [MV_W-1:0]  ref_mv,
    output logic [SAD_W-1:0] st_sad,
    output logic [MV_W-1:0]  st_mv,
    output logic             vld
);
    logic take;

    // strictly-smaller test; ties keep the reference
    always_comb take = in_win && (cur_sad < ref_sad);

    // stored minimum and its vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_sad <= '1;
            st_mv  <= '0;
        end else if (mb_start) begin
            st_sad <= '1;
            st_mv  <= '0;
        end else if (in_win) begin
            st_sad <= take ? cur_sad : ref_sad;
            st_mv  <= take ? cur_mv  : ref_mv;
        end
    end

    // result-ready pulse after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= in_win && last && !mb_start;
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win && !mb_start) |=> ($stable(st_sad) && $stable(st_mv)));
    // R2
    mb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_start |=> (st_sad == '1 && st_mv == '0));
    // R6
    never_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !mb_start) |=> (st_sad <= $past(ref_sad)));
    // R7
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
endmodule

// File: rtl/chain_min_cmp.sv
// Top: one shared, chained minimum-SAD comparator element.
// Assumes: cycle_cnt advances by one per cycle through the window.
module chain_min_cmp #(
    parameter int NUM_SRC   = cmp_pkg::DEF_NUM_SRC,
    parameter int SAD_W     = cmp_pkg::DEF_SAD_W,
    parameter int MV_W      = cmp_pkg::DEF_MV_W,
    parameter int CNT_W     = cmp_pkg::DEF_CNT_W,
    parameter int START_CYC = cmp_pkg::DEF_START_CYC,
    parameter bit CHAINED   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mb_start,
    input  logic [CNT_W-1:0]         cycle_cnt,
    input  logic [NUM_SRC*SAD_W-1:0] pe_sad,
    input  logic [NUM_SRC*MV_W-1:0]  pe_mv,
    input  logic [SAD_W-1:0]         up_sad,
    input  logic [MV_W-1:0]          up_mv,
    output logic [SAD_W-1:0]         fwd_sad,
    output logic [MV_W-1:0]          fwd_mv,
    output logic                     fwd_vld
);
    logic [NUM_SRC-1:0] sel;
    logic               in_win, first, last;
    logic [SAD_W-1:0]   cur_sad, ref_sad;
    logic [MV_W-1:0]    cur_mv, ref_mv;

    slot_decode #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .START_CYC(START_CYC)) u_dec (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cycle_cnt),
        .sel(sel), .in_win(in_win), .first(first), .last(last));

    sad_pick #(.NUM_SRC(NUM_SRC), .SAD_W(SAD_W), .MV_W(MV_W)) u_pick (
        .sel(sel), .pe_sad(pe_sad), .pe_mv(pe_mv),
        .cur_sad(cur_sad), .cur_mv(cur_mv));

    ref_mux #(.SAD_W(SAD_W), .MV_W(MV_W), .CHAINED(CHAINED)) u_ref (
        .first(first), .up_sad(up_sad), .up_mv(up_mv),
        .loc_sad(fwd_sad), .loc_mv(fwd_mv),
        .ref_sad(ref_sad), .ref_mv(ref_mv));

    min_store #(.SAD_W(SAD_W), .MV_W(MV_W)) u_st (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start),
        .in_win(in_win), .last(last),
        .cur_sad(cur_sad), .cur_mv(cur_mv),
        .ref_sad(ref_sad), .ref_mv(ref_mv),
        .st_sad(fwd_sad), .st_mv(fwd_mv), .vld(fwd_vld));

    // R4
    first_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CHAINED && first && !mb_start) |=> (fwd_sad <= $past(up_sad)));
endmodule

// File: tb/test_chain_min_cmp.sv
// Scoreboard bench for chain_min_cmp with default parameters.
module test_chain_min_cmp;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int SW = 16;
    localparam int MW = 16;
    localparam int CW = 9;
    localparam int ST = 51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mb_start = 1'b0;
    logic [CW-1:0] cycle_cnt = '0;
    logic [N*SW-1:0] pe_sad = '0;
    logic [N*MW-1:0] pe_mv = '0;
    logic [SW-1:0] up_sad = '0;
    logic [MW-1:0] up_mv = '0;
    logic [SW-1:0] fwd_sad;
    logic [MW-1:0] fwd_mv;
    logic fwd_vld;

    int total = 0;
    int bad = 0;
    logic [SW+MW-1:0] exp_q[$];
    logic [SW-1:0] last_sad = '1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_min_cmp i_chain_min_cmp (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .cycle_cnt(cycle_cnt),
        .pe_sad(pe_sad), .pe_mv(pe_mv), .up_sad(up_sad), .up_mv(up_mv),
        .fwd_sad(fwd_sad), .fwd_mv(fwd_mv), .fwd_vld(fwd_vld));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: pop expected results as fwd_vld pulses (R7, R5, R6)
    always @(negedge clk) begin
        if (rst_n && fwd_vld) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected fwd_vld", 32'd1, 32'd0);
            end else begin
                logic [SW+MW-1:0] e;
                e = exp_q.pop_front();
                check("R5 fwd_sad", 32'(fwd_sad), 32'(e[SW+MW-1:MW]));
                check("R6 fwd_mv", 32'(fwd_mv), 32'(e[MW-1:0]));
            end
        end
    end

    // driver: run one window; mbs_slot = -1 for no macroblock start
    task automatic run_cand(input logic [SW-1:0] s[N], input logic [MW-1:0] m[N],
                            input logic [SW-1:0] us, input logic [MW-1:0] um,
                            input int mbs_slot);
        logic [SW-1:0] bs;
        logic [MW-1:0] bm;
        bs = us; bm = um;
        up_sad = us; up_mv = um;
        for (int c = ST - 3; c <= ST + N + 1; c++) begin
            @(negedge clk);
            if (c == ST) check("R8 R3 hold before window", 32'(fwd_sad), 32'(last_sad));
            cycle_cnt = CW'(c);
            mb_start = 1'b0;
            for (int i = 0; i < N; i++) begin
                // outside the window the sources carry tiny values (R3)
                pe_sad[i*SW +: SW] = (c >= ST && c < ST + N) ? s[i] : SW'(1);
                pe_mv[i*MW +: MW]  = (c >= ST && c < ST + N) ? m[i] : MW'(16'hdead);
            end
            if (c >= ST && c < ST + N) begin
                if (c - ST == mbs_slot) begin
                    mb_start = 1'b1;
                    bs = '1; bm = '0;
                end else if (s[c-ST] < bs) begin
                    bs = s[c-ST]; bm = m[c-ST];
                end
                if (c == ST + N - 1 && mbs_slot != N - 1) exp_q.push_back({bs, bm});
            end
        end
        @(negedge clk);
        mb_start = 1'b0;
        check("R8 hold after window", 32'(fwd_sad), 32'(bs));
        last_sad = bs;
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            check("watchdog", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] s[N];
        logic [MW-1:0] m[N];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fwd_sad", 32'(fwd_sad), 32'h0000ffff);
        check("R1 fwd_mv", 32'(fwd_mv), 32'h0);
        check("R1 fwd_vld", 32'(fwd_vld), 32'h0);
        // R4 R5: a source in the middle wins
        s = '{16'd300, 16'd120, 16'd90, 16'd200};
        m = '{16'h0101, 16'h0202, 16'h0303, 16'h0404};
        run_cand(s, m, 16'd500, 16'h0909, -1);
        // R4: upstream smallest
        s = '{16'd40, 16'd41, 16'd42, 16'd43};
        run_cand(s, m, 16'd10, 16'h0a0a, -1);
        // R6: tie upstream vs source 0, and ties among later sources
        s = '{16'd70, 16'd80, 16'd60, 16'd60};
        m = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        run_cand(s, m, 16'd70, 16'h5555, -1);
        // R6: all saturated; upstream vector kept
        s = '{16'hffff, 16'hffff, 16'hffff, 16'hffff};
        run_cand(s, m, 16'hffff, 16'h6666, -1);
        // R4: source 0 strictly below upstream
        s = '{16'd5, 16'd6, 16'd5, 16'd7};
        m = '{16'h0a01, 16'h0a02, 16'h0a03, 16'h0a04};
        run_cand(s, m, 16'd6, 16'h0b0b, -1);
        // R2: macroblock start inside the window at slot 1
        s = '{16'd3, 16'd1, 16'd900, 16'd800};
        m = '{16'h0c01, 16'h0c02, 16'h0c03, 16'h0c04};
        run_cand(s, m, 16'd50, 16'h0d0d, 1);
        // R2 R7: macroblock start on the last slot suppresses fwd_vld
        s = '{16'd4, 16'd8, 16'd9, 16'd2};
        run_cand(s, m, 16'd50, 16'h0e0e, N - 1);
        check("R2 cleared sad", 32'(fwd_sad), 32'h0000ffff);
        check("R2 cleared mv", 32'(fwd_mv), 32'h0);
        check("R7 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule